// File: doc/BRIEF.md
# Event Capture Status Register Block

This block turns single-bit event and condition inputs into fields that software reads and clears through a simple strobe interface: a write strobe, a read strobe, a 4-bit word address and 32-bit write data, with read data returned from a register one clock after the read strobe. Status bits come in two flavours. Latch-high bits catch a condition that was present for at least one cycle. Latch-low bits catch a moment when a normally-high level dropped.

Event counters count up or down on one-bit inputs, each in a wrapping and a saturating form. A further group of counters ignores the event inputs and steps once each time its word is read. A 48-bit event counter is wider than the data bus. Its low 32 bits sit at one word and its top 16 bits at the next. Reading the low word freezes a copy of the top bits, so that a later read of the high word pairs correctly with the low value already returned.

The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after `rst_n` rises.

Top module: `evt_status_regs`

## Requirements
- R1: After reset the latch-high bits, every counter, the high-word copy and `rdata` are zero, and the latch-low bits are all ones.
- R2: Word 0x0 bits [7:0] are latch-high bits. A bit becomes 1 after any cycle in which its `stk_hi_in` bit is 1, and stays 1. Writing word 0x0 clears each bit whose `wdata` bit is 1 and leaves the others unchanged. If the input is 1 in the same cycle as the clear, the bit stays 1.
- R3: Word 0x1 bits [7:0] are latch-low bits. A bit becomes 0 after any cycle in which its `stk_lo_in` bit is 0. Writing word 0x1 with a 1 in a bit position sets that bit back to 1. If the input is 0 in the same cycle, the bit stays 0.
- R4: Word 0x2 holds two 16-bit up-counters. Bits [15:0] add one per cycle with `ev_inc_wrap` high and wrap from 0xFFFF to 0. Bits [31:16] add one per cycle with `ev_inc_sat` high and stop at 0xFFFF.
- R5: A read of word 0x2 returns the counts and then clears both to zero. An event in the cycle of that read is dropped.
- R6: Word 0x3 holds two 16-bit down-counters. Bits [15:0] subtract one per `ev_dec_wrap` cycle and wrap from 0 to 0xFFFF. Bits [31:16] subtract one per `ev_dec_sat` cycle and stop at 0. A write to word 0x3 loads both fields, and the load wins over an event in the same cycle.
- R7: Word 0x4 holds four 8-bit counters that change only when word 0x4 is read. Bits [7:0] add one and wrap. Bits [15:8] add one unless at 0xFF. Bits [23:16] subtract one and wrap. Bits [31:24] subtract one unless at 0. The read returns the values from before the step. A write to word 0x4 loads all four fields and wins over a read in the same cycle.
- R8: The 48-bit counter adds one per cycle with `ev_wide` high, carrying from its low 32 bits into its top 16 bits. Word 0x6 reads bits [31:0], and word 0x7 returns the top 16 bits in [15:0] with zeros above.
- R9: A read of word 0x6 captures the top 16 bits as they stand in that cycle. A read of word 0x7 returns that captured copy, not the live value.
- R10: A write to word 0x6 loads counter bits [31:0], and a write to word 0x7 loads bits [47:32] from `wdata[15:0]`. A load wins over an event in the same cycle.
- R11: `rdata` changes only on the clock edge that ends a cycle with `rd_en` high and holds otherwise. Words 0x5 and 0x8 to 0xF read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe for the addressed word |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| stk_hi_in | input | 8 | Conditions captured by the latch-high bits |
| stk_lo_in | input | 8 | Levels whose drop is captured by the latch-low bits |
| ev_inc_wrap | input | 1 | Event for the wrapping up-counter |
| ev_inc_sat | input | 1 | Event for the saturating up-counter |
| ev_dec_wrap | input | 1 | Event for the wrapping down-counter |
| ev_dec_sat | input | 1 | Event for the saturating down-counter |
| ev_wide | input | 1 | Event for the 48-bit counter |

## Verification
Most state in this block is seen only through reads, so a fault shows up on `rdata` one cycle after the next read of the affected word. A latch or counter that drifts stays wrong until it is cleared or reloaded, which makes a later read expose it. A wrong or missing read side effect, such as no clear, a wrong step or a step past the limit, only appears on the second read of the same word. A fault in the high-word copy appears only when events carry between the two halves in the gap between the low read and the high read. The bench therefore runs a reference model beside the design and compares every read, with directed sequences aimed at saturation, wrap and same-cycle priority.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;

  localparam int unsigned ADDR_W = 4;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  // Word offsets
  localparam reg_addr_t OFS_STK_HI  = 4'h0;
  localparam reg_addr_t OFS_STK_LO  = 4'h1;
  localparam reg_addr_t OFS_EV_INC  = 4'h2;
  localparam reg_addr_t OFS_EV_DEC  = 4'h3;
  localparam reg_addr_t OFS_RD_FX   = 4'h4;
  localparam reg_addr_t OFS_WIDE_LO = 4'h6;
  localparam reg_addr_t OFS_WIDE_HI = 4'h7;

endpackage

// File: rtl/stat_sticky.sv
// Vector of latching status bits. LOW_ACTIVE=0 latches a high condition
// (software clears with write-1); LOW_ACTIVE=1 latches a low level
// (software re-arms with write-1). The input always wins over software.
module stat_sticky #(
  parameter int unsigned N          = 8,
  parameter bit          LOW_ACTIVE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         sw_hit,
  input  logic [N-1:0] sw_mask,
  output logic [N-1:0] q
);

  localparam logic [N-1:0] RST_VAL = LOW_ACTIVE ? {N{1'b1}} : {N{1'b0}};

  logic [N-1:0] q_q;
  logic [N-1:0] q_d;
  logic [N-1:0] sw_bits;
  logic         upd;

  assign sw_bits = sw_hit ? sw_mask : '0;

  if (LOW_ACTIVE) begin : g_low
    always_comb begin
      q_d = (q_q | sw_bits) & cond;
      upd = sw_hit | ~(&cond);
    end
  end else begin : g_high
    always_comb begin
      q_d = (q_q & ~sw_bits) | cond;
      upd = sw_hit | (|cond);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= RST_VAL;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    if (LOW_ACTIVE) begin : g_low_chk
      // R3: a low input forces the bit to 0 on the next edge
      p_stlow_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cond[i] |=> !q[i]);
      // R3: a cleared bit stays 0 without a re-arm write
      p_stlow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q[i] && !(sw_hit && sw_mask[i])) |=> !q[i]);
    end else begin : g_high_chk
      // R2: a high input sets the bit on the next edge, even during a clear
      p_sticky_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cond[i] |=> q[i]);
      // R2: a set bit stays 1 without a clear write
      p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q[i] && !(sw_hit && sw_mask[i])) |=> q[i]);
    end
  end

endmodule

// File: rtl/stat_counter.sv
// Generic step counter: load has priority, then one step per enabled cycle.
// UP selects direction; SAT makes it stop at all ones (up) or zero (down).
module stat_counter #(
  parameter int unsigned W   = 16,
  parameter bit          UP  = 1'b1,
  parameter bit          SAT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] LIMIT = UP ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         blocked;
  logic         upd;

  assign blocked = SAT && (q_q == LIMIT);

  always_comb begin
    q_d = q_q;
    upd = 1'b0;
    if (ld) begin
      q_d = ld_val;
      upd = 1'b1;
    end else if (step_en && !blocked) begin
      q_d = UP ? (q_q + 1'b1) : (q_q - 1'b1);
      upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

  // R6 R7 R10: a load takes the loaded value regardless of a step
  p_cnt_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val));

  // R4: no load and no step keeps the value
  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !step_en) |=> $stable(q));

  if (UP) begin : g_up_chk
    // R4 R7 R8: an unblocked step adds exactly one
    p_cnt_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld && !(SAT && q == LIMIT)) |=> q == W'($past(q) + 1'b1));
  end else begin : g_dn_chk
    // R6 R7: an unblocked step subtracts exactly one
    p_cnt_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld && !(SAT && q == LIMIT)) |=> q == W'($past(q) - 1'b1));
  end

  if (SAT) begin : g_sat_chk
    // R4 R6 R7: a saturated counter does not move on a step
    p_cnt_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld && q == LIMIT) |=> q == LIMIT);
  end

endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs
  import evt_stat_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_STK = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RFX_W   = 8,
  parameter int unsigned WIDE_W  = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_STK-1:0]  stk_hi_in,
  input  logic [NUM_STK-1:0]  stk_lo_in,
  input  logic                ev_inc_wrap,
  input  logic                ev_inc_sat,
  input  logic                ev_dec_wrap,
  input  logic                ev_dec_sat,
  input  logic                ev_wide
);

  localparam int unsigned HI_W    = WIDE_W - DATA_W;
  localparam int unsigned N_EVCNT = 4;
  localparam int unsigned N_RFX   = 4;

  // ---------------------------------------------------------------- reset
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  // --------------------------------------------------------------- decode
  logic wr_stk_hi, wr_stk_lo, wr_ev_dec, wr_rd_fx, wr_wide_lo, wr_wide_hi;
  logic rd_ev_inc, rd_rd_fx, rd_wide_lo;
  logic mapped;

  always_comb begin
    wr_stk_hi  = wr_en && (addr == OFS_STK_HI);
    wr_stk_lo  = wr_en && (addr == OFS_STK_LO);
    wr_ev_dec  = wr_en && (addr == OFS_EV_DEC);
    wr_rd_fx   = wr_en && (addr == OFS_RD_FX);
    wr_wide_lo = wr_en && (addr == OFS_WIDE_LO);
    wr_wide_hi = wr_en && (addr == OFS_WIDE_HI);
    rd_ev_inc  = rd_en && (addr == OFS_EV_INC);
    rd_rd_fx   = rd_en && (addr == OFS_RD_FX);
    rd_wide_lo = rd_en && (addr == OFS_WIDE_LO);
    mapped     = (addr == OFS_STK_HI) || (addr == OFS_STK_LO) ||
                 (addr == OFS_EV_INC) || (addr == OFS_EV_DEC) ||
                 (addr == OFS_RD_FX)  || (addr == OFS_WIDE_LO) ||
                 (addr == OFS_WIDE_HI);
  end

  // --------------------------------------------------------- status bits
  logic [NUM_STK-1:0] skh_q;
  logic [NUM_STK-1:0] skl_q;

  stat_sticky #(.N(NUM_STK), .LOW_ACTIVE(1'b0)) u_stk_hi (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cond    (stk_hi_in),
    .sw_hit  (wr_stk_hi),
    .sw_mask (wdata[NUM_STK-1:0]),
    .q       (skh_q)
  );

  stat_sticky #(.N(NUM_STK), .LOW_ACTIVE(1'b1)) u_stk_lo (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cond    (stk_lo_in),
    .sw_hit  (wr_stk_lo),
    .sw_mask (wdata[NUM_STK-1:0]),
    .q       (skl_q)
  );

  // ------------------------------------------------------ event counters
  // index 0: up wrap, 1: up sat (word 0x2); 2: down wrap, 3: down sat (0x3)
  logic [N_EVCNT-1:0]            ev_vec;
  logic [N_EVCNT-1:0][CNT_W-1:0] cnt_q;

  assign ev_vec = {ev_dec_sat, ev_dec_wrap, ev_inc_sat, ev_inc_wrap};

  for (genvar k = 0; k < N_EVCNT; k++) begin : g_evcnt
    localparam bit IS_UP  = (k < 2);
    localparam bit IS_SAT = ((k % 2) == 1);
    logic             c_ld;
    logic [CNT_W-1:0] c_val;
    if (IS_UP) begin : g_cor
      assign c_ld  = rd_ev_inc;
      assign c_val = '0;
    end else begin : g_ldw
      assign c_ld  = wr_ev_dec;
      assign c_val = wdata[(k-2)*CNT_W +: CNT_W];
    end
    stat_counter #(.W(CNT_W), .UP(IS_UP), .SAT(IS_SAT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .step_en (ev_vec[k]),
      .ld      (c_ld),
      .ld_val  (c_val),
      .q       (cnt_q[k])
    );
  end

  // ------------------------------------------------ read-stepped counters
  // index 0: up wrap, 1: up sat, 2: down wrap, 3: down sat
  logic [N_RFX-1:0][RFX_W-1:0] rfx_q;

  for (genvar k = 0; k < N_RFX; k++) begin : g_rfx
    stat_counter #(.W(RFX_W), .UP(k < 2), .SAT((k % 2) == 1)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .step_en (rd_rd_fx),
      .ld      (wr_rd_fx),
      .ld_val  (wdata[k*RFX_W +: RFX_W]),
      .q       (rfx_q[k])
    );
  end

  // --------------------------------------------------- wide event counter
  logic [WIDE_W-1:0] wide_q;
  logic [WIDE_W-1:0] wide_ld_val;
  logic [HI_W-1:0]   snap_q;

  always_comb begin
    if (wr_wide_hi) begin
      wide_ld_val = {wdata[HI_W-1:0], wide_q[DATA_W-1:0]};
    end else begin
      wide_ld_val = {wide_q[WIDE_W-1:DATA_W], wdata};
    end
  end

  stat_counter #(.W(WIDE_W), .UP(1'b1), .SAT(1'b0)) u_wide (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .step_en (ev_wide),
    .ld      (wr_wide_lo | wr_wide_hi),
    .ld_val  (wide_ld_val),
    .q       (wide_q)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      snap_q <= '0;
    end else if (rd_wide_lo) begin
      snap_q <= wide_q[WIDE_W-1:DATA_W];
    end
  end

  // ------------------------------------------------------------ read path
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_STK_HI:  rd_mux[NUM_STK-1:0]    = skh_q;
      OFS_STK_LO:  rd_mux[NUM_STK-1:0]    = skl_q;
      OFS_EV_INC:  rd_mux[2*CNT_W-1:0]    = {cnt_q[1], cnt_q[0]};
      OFS_EV_DEC:  rd_mux[2*CNT_W-1:0]    = {cnt_q[3], cnt_q[2]};
      OFS_RD_FX:   rd_mux[N_RFX*RFX_W-1:0] = rfx_q;
      OFS_WIDE_LO: rd_mux                 = wide_q[DATA_W-1:0];
      OFS_WIDE_HI: rd_mux[HI_W-1:0]       = snap_q;
      default:     rd_mux                 = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;

  // ----------------------------------------------------------- assertions
  // R11: unmapped words read as zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && !mapped) |=> rdata == '0);

  // R11: read data holds between reads
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_en |=> $stable(rdata));

  // R5: reading the up-counter word leaves both counters at zero
  p_cor_clear_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_ev_inc |=> (cnt_q[0] == '0 && cnt_q[1] == '0));

  // R9: a high read right after a low read returns the top bits of the low-read cycle
  p_snap_pair_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && addr == OFS_WIDE_HI && $past(rd_wide_lo))
      |=> rdata[HI_W-1:0] == $past(wide_q[WIDE_W-1:DATA_W], 2));

  // R10: a low-word write lands in the counter despite an event
  p_wide_load_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_wide_lo |=> wide_q[DATA_W-1:0] == $past(wdata));

endmodule

// File: tb/evt_status_regs_tb.sv
module evt_status_regs_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  stk_hi_in;
  logic [7:0]  stk_lo_in;
  logic        ev_inc_wrap;
  logic        ev_inc_sat;
  logic        ev_dec_wrap;
  logic        ev_dec_sat;
  logic        ev_wide;

  int unsigned n_cmp;
  int unsigned n_bad;
  bit          finished;

  // reference model state
  logic [7:0]  m_skh, m_skl;
  logic [15:0] m_iw, m_is, m_dw, m_ds;
  logic [7:0]  m_rf0, m_rf1, m_rf2, m_rf3;
  logic [47:0] m_wide;
  logic [15:0] m_snap;
  logic [31:0] m_rdata;

  evt_status_regs u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .stk_hi_in   (stk_hi_in),
    .stk_lo_in   (stk_lo_in),
    .ev_inc_wrap (ev_inc_wrap),
    .ev_inc_sat  (ev_inc_sat),
    .ev_dec_wrap (ev_dec_wrap),
    .ev_dec_sat  (ev_dec_sat),
    .ev_wide     (ev_wide)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10ns clk = ~clk;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return {24'h0, m_skh};
      4'h1: return {24'h0, m_skl};
      4'h2: return {m_is, m_iw};
      4'h3: return {m_ds, m_dw};
      4'h4: return {m_rf3, m_rf2, m_rf1, m_rf0};
      4'h6: return m_wide[31:0];
      4'h7: return {16'h0, m_snap};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] rv;
    logic [7:0]  msk;
    rv  = model_read(addr);
    msk = wdata[7:0];
    if (rd_en && addr == 4'h6) m_snap = m_wide[47:32];
    // R2 / R3
    m_skh = (m_skh & ~((wr_en && addr == 4'h0) ? msk : 8'h0)) | stk_hi_in;
    m_skl = (m_skl | ((wr_en && addr == 4'h1) ? msk : 8'h0)) & stk_lo_in;
    // R4 / R5
    if (rd_en && addr == 4'h2) begin
      m_iw = '0; m_is = '0;
    end else begin
      m_iw = m_iw + {15'h0, ev_inc_wrap};
      if (ev_inc_sat && m_is != 16'hFFFF) m_is = m_is + 16'h1;
    end
    // R6
    if (wr_en && addr == 4'h3) begin
      m_dw = wdata[15:0]; m_ds = wdata[31:16];
    end else begin
      m_dw = m_dw - {15'h0, ev_dec_wrap};
      if (ev_dec_sat && m_ds != 16'h0) m_ds = m_ds - 16'h1;
    end
    // R7
    if (wr_en && addr == 4'h4) begin
      {m_rf3, m_rf2, m_rf1, m_rf0} = wdata;
    end else if (rd_en && addr == 4'h4) begin
      m_rf0 = m_rf0 + 8'h1;
      if (m_rf1 != 8'hFF) m_rf1 = m_rf1 + 8'h1;
      m_rf2 = m_rf2 - 8'h1;
      if (m_rf3 != 8'h00) m_rf3 = m_rf3 - 8'h1;
    end
    // R8 / R10
    if (wr_en && addr == 4'h6)      m_wide[31:0]  = wdata;
    else if (wr_en && addr == 4'h7) m_wide[47:32] = wdata[15:0];
    else if (ev_wide)               m_wide        = m_wide + 48'h1;
    if (rd_en) m_rdata = rv;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    stk_hi_in = '0; stk_lo_in = '1;
    ev_inc_wrap = 0; ev_inc_sat = 0; ev_dec_wrap = 0; ev_dec_sat = 0; ev_wide = 0;
  endtask

  task automatic do_read(input logic [3:0] a, input string tag, input logic [31:0] exp);
    rd_en = 1; addr = a;
    tick();
    rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic events_on(input bit v);
    ev_inc_wrap = v; ev_inc_sat = v; ev_dec_wrap = v; ev_dec_sat = v;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4_000_000ns);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_val;
    n_cmp = 0; n_bad = 0; finished = 0;
    m_skh = '0; m_skl = '1; m_iw = '0; m_is = '0; m_dw = '0; m_ds = '0;
    m_rf0 = '0; m_rf1 = '0; m_rf2 = '0; m_rf3 = '0;
    m_wide = '0; m_snap = '0; m_rdata = '0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();

    // R1: reset state
    chk("R1 rdata after reset", rdata, 32'h0);
    do_read(4'h0, "R1 latch-high", 32'h0);
    do_read(4'h1, "R1 latch-low", 32'h0000_00FF);
    do_read(4'h2, "R1 up counters", 32'h0);
    do_read(4'h3, "R1 down counters", 32'h0);
    do_read(4'h4, "R1 read-stepped", 32'h0);
    do_read(4'h6, "R1 wide low", 32'h0);
    do_read(4'h7, "R1 wide high", 32'h0);
    // that read of 0x4 stepped the read-stepped counters: reload zero
    do_write(4'h4, 32'h0);

    // R2
    stk_hi_in = 8'h05; tick(); stk_hi_in = 8'h00; tick(); tick();
    do_read(4'h0, "R2 capture", 32'h05);
    stk_hi_in = 8'h01; do_write(4'h0, 32'h01); stk_hi_in = 8'h00;
    do_read(4'h0, "R2 event beats clear", 32'h05);
    do_write(4'h0, 32'h04);
    do_read(4'h0, "R2 write-1 clear per bit", 32'h01);

    // R3
    stk_lo_in = 8'hFE; tick(); stk_lo_in = 8'hFF;
    do_read(4'h1, "R3 capture low", 32'hFE);
    stk_lo_in = 8'hFE; do_write(4'h1, 32'h01); stk_lo_in = 8'hFF;
    do_read(4'h1, "R3 low beats re-arm", 32'hFE);
    do_write(4'h1, 32'h01);
    do_read(4'h1, "R3 re-arm", 32'hFF);

    // R4 / R5
    ev_inc_wrap = 1; ev_inc_sat = 1; repeat (5) tick();
    ev_inc_wrap = 0; ev_inc_sat = 0;
    do_read(4'h2, "R4 count five", 32'h0005_0005);
    do_read(4'h2, "R5 clear on read", 32'h0);
    ev_inc_wrap = 1; ev_inc_sat = 1; repeat (65540) tick();
    ev_inc_wrap = 0; ev_inc_sat = 0;
    do_read(4'h2, "R4 wrap and saturate", 32'hFFFF_0004);
    ev_inc_wrap = 1; ev_inc_sat = 1; repeat (3) tick();
    do_read(4'h2, "R5 read with event", 32'h0003_0003);
    ev_inc_wrap = 0; ev_inc_sat = 0;
    do_read(4'h2, "R5 event dropped on clear", 32'h0);

    // R6
    do_write(4'h3, 32'h0002_0001);
    ev_dec_wrap = 1; ev_dec_sat = 1; repeat (3) tick();
    ev_dec_wrap = 0; ev_dec_sat = 0;
    do_read(4'h3, "R6 wrap and floor", 32'h0000_FFFE);
    ev_dec_wrap = 1; ev_dec_sat = 1;
    do_write(4'h3, 32'h0010_0010);
    ev_dec_wrap = 0; ev_dec_sat = 0;
    do_read(4'h3, "R6 load beats event", 32'h0010_0010);

    // R7
    do_write(4'h4, 32'h0100_FEFF);
    do_read(4'h4, "R7 first read", 32'h0100_FEFF);
    do_read(4'h4, "R7 second read", 32'h00FF_FF00);
    do_read(4'h4, "R7 third read", 32'h00FE_FF01);
    wr_en = 1; rd_en = 1; addr = 4'h4; wdata = 32'h1122_3344;
    tick();
    wr_en = 0; rd_en = 0;
    chk("R7 read during write", rdata, 32'h00FD_FF02);
    do_read(4'h4, "R7 write beats step", 32'h1122_3344);

    // R8 / R9 / R10
    do_write(4'h6, 32'hFFFF_FFF0);
    do_write(4'h7, 32'h0000_0005);
    do_read(4'h6, "R10 low load", 32'hFFFF_FFF0);
    ev_wide = 1; repeat (40) tick(); ev_wide = 0;
    do_read(4'h7, "R9 captured high", 32'h0000_0005);
    do_read(4'h6, "R8 low after carry", 32'h0000_0018);
    do_read(4'h7, "R8 high after carry", 32'h0000_0006);
    ev_wide = 1; do_write(4'h6, 32'h0000_0100); ev_wide = 0;
    do_read(4'h6, "R10 load beats event", 32'h0000_0100);

    // R11
    repeat (3) tick();
    chk("R11 rdata holds", rdata, 32'h0000_0100);
    do_write(4'h5, 32'hFFFF_FFFF);
    do_read(4'h5, "R11 unmapped 0x5", 32'h0);
    do_read(4'hF, "R11 unmapped 0xF", 32'h0);
    do_read(4'h6, "R11 write to 0x5 ignored", 32'h0000_0100);

    // constrained random against the model
    seed_val = $urandom(32'h00C0_FFEE);
    for (int i = 0; i < 4000; i++) begin
      bit was_rd;
      wr_en       = ($urandom % 8) == 0;
      rd_en       = ($urandom % 3) == 0;
      addr        = 4'($urandom % 9);
      wdata       = $urandom;
      stk_hi_in   = 8'($urandom) & 8'($urandom) & 8'($urandom);
      stk_lo_in   = ~(8'($urandom) & 8'($urandom) & 8'($urandom));
      ev_inc_wrap = 1'($urandom);
      ev_inc_sat  = 1'($urandom);
      ev_dec_wrap = 1'($urandom);
      ev_dec_sat  = 1'($urandom);
      ev_wide     = 1'($urandom);
      was_rd      = rd_en;
      tick();
      if (was_rd) chk("R2-R11 random vs model", rdata, m_rdata);
    end
    idle_inputs();
    for (int a = 0; a < 8; a++) begin
      rd_en = 1; addr = 4'(a);
      tick();
      rd_en = 0;
      chk("R11 final sweep", rdata, m_rdata);
    end

    finish_run();
  end

  // unused-variable guard for the seed return
  initial begin
    if (0) chk("R1 never", 32'h0, 32'h0);
  end

endmodule